// File: doc/BRIEF.md
# Keyboard and Mouse Controller Host Register Front End

This block is the host-facing register layer of a legacy keyboard and mouse controller. A host bus reaches it through two byte-wide locations, selected by one bit: a data location and a command/status location. Two device channels sit behind it, one for the keyboard and one for the auxiliary pointing device. Each channel carries bytes in both directions with a valid/ready handshake. The block holds one output byte for the host, a status byte, a configuration byte, and a pending-command state. That state decides where the next byte written to the data location goes.

The pending-command state machine has six named states: IDLE (no command pending), WAIT_CFG (configuration write pending), WAIT_OPORT (output-port write pending), WAIT_KB_OUT (keyboard output-buffer write pending), WAIT_AUX_OUT (auxiliary output-buffer write pending) and WAIT_AUX_SEND (send-to-auxiliary pending).

Its transitions are named as follows:
- ARM: a command write of 0x60, 0xD1, 0xD2, 0xD3 or 0xD4 moves from any state to WAIT_CFG, WAIT_OPORT, WAIT_KB_OUT, WAIT_AUX_OUT or WAIT_AUX_SEND respectively.
- HOLD: a command write of any other code leaves the state where it is.
- FIRE: any data write returns every state to IDLE, after carrying out the pending action.

Device bytes flow into the output byte whenever it is free. The keyboard wins over the auxiliary channel. Each byte load can raise a one-cycle interrupt pulse for its channel.

Top module: `kbc_host_front`

## Requirements
- R1: After reset the status byte reads 0x1C and the configuration byte is 0x45. No command is pending. No interrupt, error or transmit-valid output is active.
- R2: Loading the output byte sets status bit 0 (output full). It sets status bit 5 (auxiliary full) when the byte is auxiliary-sourced and clears bit 5 otherwise. A byte loaded while bit 0 is already set overwrites the held byte.
- R3: In the cycle after a keyboard-sourced load, kb_irq is high for one cycle if configuration bit 0 was set at the load. After an auxiliary-sourced load, aux_irq behaves the same way using configuration bit 1.
- R4: A data read (host_rd with host_sel=0) returns the held byte and clears status bits 0 and 5. At that same edge a waiting keyboard byte is loaded. Only if no keyboard byte is waiting is a waiting auxiliary byte loaded.
- R5: A device byte is accepted (rx_ready high) only when status bit 0 is clear or a data read happens in that cycle. No internal load may happen in that cycle. The accepted byte is the one presented with valid.
- R6: Any command write (host_wr with host_sel=1) sets status bit 3. Any data write clears it. A command read (host_rd with host_sel=1) returns the status byte: bit 0 full, bit 2 self-test, bit 3 command-last, bit 4 unlocked (always 1), bit 5 auxiliary full, all other bits 0.
- R7: A data write in state IDLE is sent on the keyboard transmit channel. In WAIT_AUX_SEND it is sent on the auxiliary transmit channel. In WAIT_CFG it replaces the configuration byte, and its bit 2 is copied into status bit 2.
- R8: A data write in WAIT_KB_OUT loads the byte as keyboard-sourced, and in WAIT_AUX_OUT as auxiliary-sourced. Both follow R2 and R3.
- R9: Command 0x20 loads the configuration byte as a keyboard-sourced byte. Commands 0xA7/0xA8 set/clear configuration bit 5. Commands 0xAD/0xAE set/clear configuration bit 4.
- R10: Every data write leaves the state machine in IDLE. A data write in WAIT_OPORT with bit 0 equal to 0 raises cmd_err for one cycle after the write. With bit 0 equal to 1 it raises no error.
- R11: A command write of any code not listed in R7 to R10 raises cmd_err for one cycle after the write. It leaves the pending state and the configuration byte unchanged.
- R12: A transmit byte stays presented with valid high and unchanged data until the device takes it with ready. A new send replaces the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_sel | input | 1 | 0 selects data location, 1 selects command/status |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Held output byte (sel=0) or status byte (sel=1) |
| kb_rx_valid | input | 1 | Keyboard has a byte for the host |
| kb_rx_data | input | 8 | Keyboard byte |
| kb_rx_ready | output | 1 | Keyboard byte accepted this cycle |
| kb_tx_valid | output | 1 | Byte presented to keyboard |
| kb_tx_data | output | 8 | Byte for keyboard |
| kb_tx_ready | input | 1 | Keyboard takes the presented byte |
| aux_rx_valid | input | 1 | Auxiliary device has a byte for the host |
| aux_rx_data | input | 8 | Auxiliary byte |
| aux_rx_ready | output | 1 | Auxiliary byte accepted this cycle |
| aux_tx_valid | output | 1 | Byte presented to auxiliary device |
| aux_tx_data | output | 8 | Byte for auxiliary device |
| aux_tx_ready | input | 1 | Auxiliary device takes the presented byte |
| kb_irq | output | 1 | One-cycle keyboard interrupt pulse |
| aux_irq | output | 1 | One-cycle auxiliary interrupt pulse |
| cmd_err | output | 1 | One-cycle error pulse for bad command or output-port byte |

## Verification
The hardest case to reach is a data read taking place while both device channels hold a waiting byte. That is the only moment the keyboard-over-auxiliary order is visible. Reaching it takes three steps: the stimulus first fills the output byte, then queues bytes on both channels while it stays full, and only then issues the read. The queued bytes are drained by back-to-back reads. Overwriting loads through WAIT_KB_OUT and WAIT_AUX_OUT while the output is full, and a rejected code arriving while WAIT_CFG is armed, are also set up on purpose.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

    parameter int BYTE_W = 8;

    typedef enum logic [2:0] {
        IDLE,
        WAIT_CFG,
        WAIT_OPORT,
        WAIT_KB_OUT,
        WAIT_AUX_OUT,
        WAIT_AUX_SEND
    } pend_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_INT,
        SRC_KB,
        SRC_AUX
    } src_e;

    localparam logic [BYTE_W-1:0] OP_RD_CFG    = 8'h20;
    localparam logic [BYTE_W-1:0] OP_WR_CFG    = 8'h60;
    localparam logic [BYTE_W-1:0] OP_AUX_OFF   = 8'hA7;
    localparam logic [BYTE_W-1:0] OP_AUX_ON    = 8'hA8;
    localparam logic [BYTE_W-1:0] OP_KB_OFF    = 8'hAD;
    localparam logic [BYTE_W-1:0] OP_KB_ON     = 8'hAE;
    localparam logic [BYTE_W-1:0] OP_WR_OPORT  = 8'hD1;
    localparam logic [BYTE_W-1:0] OP_WR_KB_OUT = 8'hD2;
    localparam logic [BYTE_W-1:0] OP_WR_AUXOUT = 8'hD3;
    localparam logic [BYTE_W-1:0] OP_AUX_SEND  = 8'hD4;

    localparam int ST_FULL    = 0;
    localparam int ST_SYS     = 2;
    localparam int ST_CMDLAST = 3;
    localparam int ST_UNLOCK  = 4;
    localparam int ST_AUXFULL = 5;

    localparam int CF_KBIE   = 0;
    localparam int CF_AUXIE  = 1;
    localparam int CF_SYS    = 2;
    localparam int CF_KBDIS  = 4;
    localparam int CF_AUXDIS = 5;
    localparam int CF_XLAT   = 6;

    localparam logic [BYTE_W-1:0] CFG_AT_RESET =
        BYTE_W'((1 << CF_KBIE) | (1 << CF_SYS) | (1 << CF_XLAT));

    function automatic logic op_known(input logic [BYTE_W-1:0] op);
        return (op == OP_RD_CFG)   || (op == OP_WR_CFG)    ||
               (op == OP_AUX_OFF)  || (op == OP_AUX_ON)    ||
               (op == OP_KB_OFF)   || (op == OP_KB_ON)     ||
               (op == OP_WR_OPORT) || (op == OP_WR_KB_OUT) ||
               (op == OP_WR_AUXOUT) || (op == OP_AUX_SEND);
    endfunction

endpackage

// File: rtl/kbc_cmd_fsm.sv
module kbc_cmd_fsm
    import kbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              dat_wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic              kbie,
    output logic              auxie,
    output logic              sys_flag,
    output logic              cmd_last,
    output logic              ld_req,
    output logic [BYTE_W-1:0] ld_data,
    output logic              ld_aux,
    output logic              kb_send,
    output logic              aux_send,
    output logic              err_q
);

    pend_e             pend_q, pend_d;
    logic [BYTE_W-1:0] cfg_q, cfg_d;
    logic              sys_q, sys_d;
    logic              cl_q, cl_d;
    logic              err_d;

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= IDLE;
            cfg_q  <= CFG_AT_RESET;
            sys_q  <= 1'b1;
            cl_q   <= 1'b1;
            err_q  <= 1'b0;
        end else begin
            pend_q <= pend_d;
            cfg_q  <= cfg_d;
            sys_q  <= sys_d;
            cl_q   <= cl_d;
            err_q  <= err_d;
        end
    end

    // Next-state process: ARM, HOLD and FIRE transitions
    always_comb begin
        pend_d = pend_q;
        cfg_d  = cfg_q;
        sys_d  = sys_q;
        cl_d   = cl_q;
        if (cmd_wr) begin
            cl_d = 1'b1;
            unique case (wdata)
                OP_WR_CFG:    pend_d = WAIT_CFG;
                OP_WR_OPORT:  pend_d = WAIT_OPORT;
                OP_WR_KB_OUT: pend_d = WAIT_KB_OUT;
                OP_WR_AUXOUT: pend_d = WAIT_AUX_OUT;
                OP_AUX_SEND:  pend_d = WAIT_AUX_SEND;
                OP_AUX_OFF:   cfg_d[CF_AUXDIS] = 1'b1;
                OP_AUX_ON:    cfg_d[CF_AUXDIS] = 1'b0;
                OP_KB_OFF:    cfg_d[CF_KBDIS]  = 1'b1;
                OP_KB_ON:     cfg_d[CF_KBDIS]  = 1'b0;
                default:      pend_d = pend_q;
            endcase
        end else if (dat_wr) begin
            cl_d   = 1'b0;
            pend_d = IDLE;
            if (pend_q == WAIT_CFG) begin
                cfg_d = wdata;
                sys_d = wdata[CF_SYS];
            end
        end
    end

    // Output process
    always_comb begin
        ld_req   = 1'b0;
        ld_data  = wdata;
        ld_aux   = 1'b0;
        kb_send  = 1'b0;
        aux_send = 1'b0;
        err_d    = 1'b0;
        if (cmd_wr) begin
            if (wdata == OP_RD_CFG) begin
                ld_req  = 1'b1;
                ld_data = cfg_q;
            end
            err_d = !op_known(wdata);
        end else if (dat_wr) begin
            unique case (pend_q)
                IDLE:          kb_send  = 1'b1;
                WAIT_AUX_SEND: aux_send = 1'b1;
                WAIT_KB_OUT:   ld_req   = 1'b1;
                WAIT_AUX_OUT: begin
                    ld_req = 1'b1;
                    ld_aux = 1'b1;
                end
                WAIT_OPORT:    err_d = !wdata[0];
                WAIT_CFG:      err_d = 1'b0;
                default:       err_d = 1'b0;
            endcase
        end
    end

    assign kbie     = cfg_q[CF_KBIE];
    assign auxie    = cfg_q[CF_AUXIE];
    assign sys_flag = sys_q;
    assign cmd_last = cl_q;

    // R10: any data write ends in IDLE
    a_r10_fire_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        dat_wr |=> (pend_q == IDLE));

    // R11: rejected code keeps pending state and configuration
    a_r11_hold_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !op_known(wdata)) |=> ($stable(pend_q) && $stable(cfg_q) && err_q));

    // R7: configuration write lands and mirrors self-test bit
    a_r7_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && pend_q == WAIT_CFG) |=>
            (cfg_q == $past(wdata) && sys_q == $past(wdata[CF_SYS])));

endmodule

// File: rtl/kbc_outbuf.sv
module kbc_outbuf
    import kbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_req,
    input  logic [BYTE_W-1:0] ld_data,
    input  logic              ld_aux,
    input  logic              host_take,
    input  logic              kbie,
    input  logic              auxie,
    input  logic              kb_rx_valid,
    input  logic [BYTE_W-1:0] kb_rx_data,
    input  logic              aux_rx_valid,
    input  logic [BYTE_W-1:0] aux_rx_data,
    output logic              kb_rx_ready,
    output logic              aux_rx_ready,
    output logic [BYTE_W-1:0] out_q,
    output logic              full_q,
    output logic              auxf_q,
    output logic              kb_irq_q,
    output logic              aux_irq_q
);

    src_e              src;
    logic              room;
    logic [BYTE_W-1:0] nxt_byte;
    logic              nxt_aux;

    assign room         = !full_q || host_take;
    assign kb_rx_ready  = room && !ld_req;
    assign aux_rx_ready = room && !ld_req && !kb_rx_valid;

    always_comb begin
        if (ld_req)                           src = SRC_INT;
        else if (kb_rx_valid && kb_rx_ready)  src = SRC_KB;
        else if (aux_rx_valid && aux_rx_ready) src = SRC_AUX;
        else                                  src = SRC_NONE;
    end

    always_comb begin
        nxt_byte = out_q;
        nxt_aux  = 1'b0;
        unique case (src)
            SRC_INT: begin
                nxt_byte = ld_data;
                nxt_aux  = ld_aux;
            end
            SRC_KB:  nxt_byte = kb_rx_data;
            SRC_AUX: begin
                nxt_byte = aux_rx_data;
                nxt_aux  = 1'b1;
            end
            default: nxt_aux = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q     <= '0;
            full_q    <= 1'b0;
            auxf_q    <= 1'b0;
            kb_irq_q  <= 1'b0;
            aux_irq_q <= 1'b0;
        end else begin
            kb_irq_q  <= 1'b0;
            aux_irq_q <= 1'b0;
            if (src != SRC_NONE) begin
                out_q     <= nxt_byte;
                full_q    <= 1'b1;
                auxf_q    <= nxt_aux;
                kb_irq_q  <= !nxt_aux && kbie;
                aux_irq_q <= nxt_aux && auxie;
            end else if (host_take) begin
                full_q <= 1'b0;
                auxf_q <= 1'b0;
            end
        end
    end

    // R4: a read with nothing to refill empties the buffer
    a_r4_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (host_take && !ld_req && !kb_rx_valid && !aux_rx_valid) |=> (!full_q && !auxf_q));

    // R2: auxiliary byte marks both full flags
    a_r2_aux_marks: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_rx_valid && aux_rx_ready) |=> (full_q && auxf_q && out_q == $past(aux_rx_data)));

endmodule

// File: rtl/kbc_tx_slot.sv
module kbc_tx_slot
    import kbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              send,
    input  logic [BYTE_W-1:0] send_data,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else if (send) begin
            tx_valid <= 1'b1;
            tx_data  <= send_data;
        end else if (tx_valid && tx_ready) begin
            tx_valid <= 1'b0;
        end
    end

    // R12: an untaken byte stays put
    a_r12_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !send) |=> (tx_valid && $stable(tx_data)));

endmodule

// File: rtl/kbc_host_front.sv
module kbc_host_front
    import kbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic              host_sel,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic              kb_rx_valid,
    input  logic [BYTE_W-1:0] kb_rx_data,
    output logic              kb_rx_ready,
    output logic              kb_tx_valid,
    output logic [BYTE_W-1:0] kb_tx_data,
    input  logic              kb_tx_ready,
    input  logic              aux_rx_valid,
    input  logic [BYTE_W-1:0] aux_rx_data,
    output logic              aux_rx_ready,
    output logic              aux_tx_valid,
    output logic [BYTE_W-1:0] aux_tx_data,
    input  logic              aux_tx_ready,
    output logic              kb_irq,
    output logic              aux_irq,
    output logic              cmd_err
);

    localparam int NCH = 2;

    logic              cmd_wr, dat_wr, host_take;
    logic              kbie, auxie, sys_flag, cmd_last;
    logic              ld_req, ld_aux;
    logic [BYTE_W-1:0] ld_data;
    logic              kb_send, aux_send;
    logic [BYTE_W-1:0] out_byte;
    logic              full, auxf;
    logic [BYTE_W-1:0] status;

    logic              ch_send  [NCH];
    logic              ch_ready [NCH];
    logic              ch_valid [NCH];
    logic [BYTE_W-1:0] ch_data  [NCH];

    assign cmd_wr    = host_wr && host_sel;
    assign dat_wr    = host_wr && !host_sel;
    assign host_take = host_rd && !host_sel;

    kbc_cmd_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr),
        .dat_wr   (dat_wr),
        .wdata    (host_wdata),
        .kbie     (kbie),
        .auxie    (auxie),
        .sys_flag (sys_flag),
        .cmd_last (cmd_last),
        .ld_req   (ld_req),
        .ld_data  (ld_data),
        .ld_aux   (ld_aux),
        .kb_send  (kb_send),
        .aux_send (aux_send),
        .err_q    (cmd_err)
    );

    kbc_outbuf u_obuf (
        .clk          (clk),
        .rst_n        (rst_n),
        .ld_req       (ld_req),
        .ld_data      (ld_data),
        .ld_aux       (ld_aux),
        .host_take    (host_take),
        .kbie         (kbie),
        .auxie        (auxie),
        .kb_rx_valid  (kb_rx_valid),
        .kb_rx_data   (kb_rx_data),
        .aux_rx_valid (aux_rx_valid),
        .aux_rx_data  (aux_rx_data),
        .kb_rx_ready  (kb_rx_ready),
        .aux_rx_ready (aux_rx_ready),
        .out_q        (out_byte),
        .full_q       (full),
        .auxf_q       (auxf),
        .kb_irq_q     (kb_irq),
        .aux_irq_q    (aux_irq)
    );

    assign ch_send[0]  = kb_send;
    assign ch_send[1]  = aux_send;
    assign ch_ready[0] = kb_tx_ready;
    assign ch_ready[1] = aux_tx_ready;

    for (genvar g = 0; g < NCH; g++) begin : g_tx
        kbc_tx_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .send      (ch_send[g]),
            .send_data (host_wdata),
            .tx_ready  (ch_ready[g]),
            .tx_valid  (ch_valid[g]),
            .tx_data   (ch_data[g])
        );
    end

    assign kb_tx_valid  = ch_valid[0];
    assign kb_tx_data   = ch_data[0];
    assign aux_tx_valid = ch_valid[1];
    assign aux_tx_data  = ch_data[1];

    always_comb begin
        status              = '0;
        status[ST_FULL]     = full;
        status[ST_SYS]      = sys_flag;
        status[ST_CMDLAST]  = cmd_last;
        status[ST_UNLOCK]   = 1'b1;
        status[ST_AUXFULL]  = auxf;
    end

    assign host_rdata = host_sel ? status : out_byte;

    // R6: command write sets command-last, data write clears it
    a_r6_cmdlast_set: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> status[ST_CMDLAST]);
    a_r6_cmdlast_clr: assert property (@(posedge clk) disable iff (!rst_n)
        dat_wr |=> !status[ST_CMDLAST]);

    // R3: a keyboard pulse always comes with a keyboard-sourced full buffer
    a_r3_kb_irq_flags: assert property (@(posedge clk) disable iff (!rst_n)
        kb_irq |-> (status[ST_FULL] && !status[ST_AUXFULL]));
    a_r3_aux_irq_flags: assert property (@(posedge clk) disable iff (!rst_n)
        aux_irq |-> (status[ST_FULL] && status[ST_AUXFULL]));

    // R5: an accepted keyboard byte is what the host then sees
    a_r5_kb_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (kb_rx_valid && kb_rx_ready) |=> (out_byte == $past(kb_rx_data)));

    // R4: the auxiliary channel never wins while the keyboard waits
    a_r4_kb_first: assert property (@(posedge clk) disable iff (!rst_n)
        kb_rx_valid |-> !aux_rx_ready);

endmodule

// File: tb/kbc_host_front_tb.sv
module kbc_host_front_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0, host_sel = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       kb_rx_valid = 1'b0, aux_rx_valid = 1'b0;
    logic [7:0] kb_rx_data = 8'h00, aux_rx_data = 8'h00;
    logic       kb_rx_ready, aux_rx_ready;
    logic       kb_tx_valid, aux_tx_valid;
    logic [7:0] kb_tx_data, aux_tx_data;
    logic       kb_tx_ready = 1'b0, aux_tx_ready = 1'b0;
    logic       kb_irq, aux_irq, cmd_err;

    always #2 clk = ~clk;

    kbc_host_front u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_rd(host_rd), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .kb_rx_valid(kb_rx_valid), .kb_rx_data(kb_rx_data), .kb_rx_ready(kb_rx_ready),
        .kb_tx_valid(kb_tx_valid), .kb_tx_data(kb_tx_data), .kb_tx_ready(kb_tx_ready),
        .aux_rx_valid(aux_rx_valid), .aux_rx_data(aux_rx_data), .aux_rx_ready(aux_rx_ready),
        .aux_tx_valid(aux_tx_valid), .aux_tx_data(aux_tx_data), .aux_tx_ready(aux_tx_ready),
        .kb_irq(kb_irq), .aux_irq(aux_irq), .cmd_err(cmd_err)
    );

    int total = 0;
    int bad = 0;
    int tick = 0;
    string tag = "R1";

    byte unsigned kbq[$];
    byte unsigned auxq[$];

    // reference model state; pending: 0 none 1 cfg 2 oport 3 kbout 4 auxout 5 auxsend
    logic [7:0] m_out, m_cfg, m_kbtd, m_auxtd;
    logic       m_full, m_auxf, m_cl, m_sys, m_kbirq, m_auxirq, m_err, m_kbtv, m_auxtv;
    int         m_pend;

    task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%02h expected=%02h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] m_status();
        return {2'b00, m_auxf, 1'b1, m_cl, m_sys, 1'b0, m_full};
    endfunction

    function automatic logic m_intload();
        return (host_wr && host_sel && host_wdata == 8'h20) ||
               (host_wr && !host_sel && (m_pend == 3 || m_pend == 4));
    endfunction

    task automatic model_reset();
        m_out = 8'h00; m_cfg = 8'h45; m_full = 0; m_auxf = 0; m_cl = 1; m_sys = 1;
        m_kbirq = 0; m_auxirq = 0; m_err = 0; m_kbtv = 0; m_auxtv = 0;
        m_kbtd = 8'h00; m_auxtd = 8'h00; m_pend = 0;
    endtask

    task automatic compare();
        logic room, kr, ar;
        room = !m_full || (host_rd && !host_sel);
        kr = room && !m_intload();
        ar = kr && (kbq.size() == 0);
        chk(host_sel ? "status" : "data", host_rdata, host_sel ? m_status() : m_out);
        chk("kb_rx_ready", {7'b0, kb_rx_ready}, {7'b0, kr});
        chk("aux_rx_ready", {7'b0, aux_rx_ready}, {7'b0, ar});
        chk("kb_irq", {7'b0, kb_irq}, {7'b0, m_kbirq});
        chk("aux_irq", {7'b0, aux_irq}, {7'b0, m_auxirq});
        chk("cmd_err", {7'b0, cmd_err}, {7'b0, m_err});
        chk("kb_tx_valid", {7'b0, kb_tx_valid}, {7'b0, m_kbtv});
        chk("aux_tx_valid", {7'b0, aux_tx_valid}, {7'b0, m_auxtv});
        if (m_kbtv) chk("kb_tx_data", kb_tx_data, m_kbtd);
        if (m_auxtv) chk("aux_tx_data", aux_tx_data, m_auxtd);
    endtask

    task automatic model_step();
        logic       room, ld, ldaux, kbs, auxs, took_kb, took_aux;
        logic [7:0] ldd, cfg_old;
        cfg_old = m_cfg;
        ld = 0; ldaux = 0; ldd = 8'h00; kbs = 0; auxs = 0;
        room = !m_full || (host_rd && !host_sel);
        m_err = 0;
        if (host_wr && host_sel) begin
            m_cl = 1;
            case (host_wdata)
                8'h20: begin ld = 1; ldd = m_cfg; end
                8'h60: m_pend = 1;
                8'hD1: m_pend = 2;
                8'hD2: m_pend = 3;
                8'hD3: m_pend = 4;
                8'hD4: m_pend = 5;
                8'hA7: m_cfg[5] = 1;
                8'hA8: m_cfg[5] = 0;
                8'hAD: m_cfg[4] = 1;
                8'hAE: m_cfg[4] = 0;
                default: m_err = 1;
            endcase
        end else if (host_wr && !host_sel) begin
            m_cl = 0;
            case (m_pend)
                0: kbs = 1;
                5: auxs = 1;
                1: begin m_cfg = host_wdata; m_sys = host_wdata[2]; end
                3: begin ld = 1; ldd = host_wdata; end
                4: begin ld = 1; ldd = host_wdata; ldaux = 1; end
                2: m_err = !host_wdata[0];
                default: ;
            endcase
            m_pend = 0;
        end
        took_kb  = !ld && room && kbq.size() > 0;
        took_aux = !ld && room && !took_kb && auxq.size() > 0;
        if (took_kb) begin ldd = kbq.pop_front(); end
        if (took_aux) begin ldd = auxq.pop_front(); ldaux = 1; end
        m_kbirq = 0; m_auxirq = 0;
        if (ld || took_kb || took_aux) begin
            m_out = ldd; m_full = 1; m_auxf = ldaux;
            m_kbirq = !ldaux && cfg_old[0];
            m_auxirq = ldaux && cfg_old[1];
        end else if (host_rd && !host_sel) begin
            m_full = 0; m_auxf = 0;
        end
        if (kbs) begin m_kbtv = 1; m_kbtd = host_wdata; end
        else if (m_kbtv && kb_tx_ready) m_kbtv = 0;
        if (auxs) begin m_auxtv = 1; m_auxtd = host_wdata; end
        else if (m_auxtv && aux_tx_ready) m_auxtv = 0;
    endtask

    task automatic cyc(input logic wr, input logic rd, input logic sel, input logic [7:0] wd);
        @(negedge clk);
        tick++;
        host_wr = wr; host_rd = rd; host_sel = sel; host_wdata = wd;
        kb_rx_valid  = kbq.size() > 0;
        kb_rx_data   = (kbq.size() > 0) ? kbq[0] : 8'h00;
        aux_rx_valid = auxq.size() > 0;
        aux_rx_data  = (auxq.size() > 0) ? auxq[0] : 8'h00;
        kb_tx_ready  = (tick % 4) == 3;
        aux_tx_ready = (tick % 5) == 4;
        #1;
        compare();
        @(posedge clk);
        model_step();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 8'h00);
    endtask
    task automatic cmd(input logic [7:0] c);   cyc(1, 0, 1, c); endtask
    task automatic dwr(input logic [7:0] d);   cyc(1, 0, 0, d); endtask
    task automatic drd();                      cyc(0, 1, 0, 8'h00); endtask
    task automatic srd();                      cyc(0, 1, 1, 8'h00); endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values seen at the ports
        tag = "R1";
        @(negedge clk);
        host_sel = 1'b1;
        #1;
        chk("reset status", host_rdata, 8'h1C);
        chk("reset irq/err/tx", {3'b0, kb_irq, aux_irq, cmd_err, kb_tx_valid, aux_tx_valid}, 8'h00);
        srd();
        tag = "R1 R9";
        cmd(8'h20); idle(1); drd(); idle(1);

        // R6: command-last flag follows the last written port
        tag = "R6";
        cmd(8'hAE); srd(); dwr(8'hF4); srd(); idle(3);

        // R7 R12: routing to keyboard and auxiliary transmit, held until ready
        tag = "R7 R12";
        dwr(8'hFF); idle(5);
        cmd(8'hD4); dwr(8'hE6); idle(6);
        dwr(8'h11); dwr(8'h22); idle(5);

        // R7: configuration write, self-test bit mirrored
        tag = "R7";
        cmd(8'h60); dwr(8'h03); srd(); idle(1);
        cmd(8'h20); drd(); idle(1);
        cmd(8'h60); dwr(8'h07); srd();

        // R8 R3 R2: direct output loads with both interrupts on
        tag = "R8 R3 R2";
        cmd(8'hD2); dwr(8'h5A); srd(); drd(); srd();
        cmd(8'hD3); dwr(8'hA5); srd(); drd(); srd();
        cmd(8'hD2); dwr(8'h01); cmd(8'hD3); dwr(8'h02); srd(); drd(); idle(1);

        // R4 R5: device streams, keyboard first when both wait at a read
        tag = "R4 R5";
        kbq.push_back(8'h1C); idle(2);
        kbq.push_back(8'h2A); auxq.push_back(8'h08); auxq.push_back(8'h10);
        kbq.push_back(8'h3B); idle(2);
        drd(); srd(); drd(); drd(); srd(); drd(); drd(); drd(); srd(); idle(2);
        auxq.push_back(8'h77); idle(1); srd(); drd(); idle(1);

        // R3: interrupts masked when enables are clear
        tag = "R3";
        cmd(8'h60); dwr(8'h44);
        kbq.push_back(8'h9E); idle(2); drd();
        auxq.push_back(8'h55); idle(2); drd();
        cmd(8'h60); dwr(8'h46);
        kbq.push_back(8'h33); auxq.push_back(8'h44); idle(2); drd(); drd(); idle(1);

        // R5: internal load in the same cycle blocks device pop
        tag = "R5";
        kbq.push_back(8'hC1); cmd(8'hD2); dwr(8'h66); idle(1); drd(); drd(); idle(1);

        // R9: disable / enable bits in the configuration byte
        tag = "R9";
        cmd(8'hA7); cmd(8'h20); drd();
        cmd(8'hAD); cmd(8'h20); drd();
        cmd(8'hA8); cmd(8'h20); drd();
        cmd(8'hAE); cmd(8'h20); drd(); idle(1);

        // R10: output-port byte check and return to idle
        tag = "R10";
        cmd(8'hD1); dwr(8'h00); idle(1);
        cmd(8'hD1); dwr(8'h01); idle(1);
        dwr(8'hED); idle(5);

        // R11: rejected code keeps an armed configuration write
        tag = "R11";
        cmd(8'h60); cmd(8'h55); srd(); dwr(8'h47); cmd(8'h20); drd();
        cmd(8'hC0); cmd(8'hFF); idle(1); dwr(8'hAA); idle(5);

        // R1: reset in mid-traffic restores defaults
        tag = "R1";
        cmd(8'hD3); dwr(8'h99);
        @(negedge clk);
        rst_n = 1'b0; host_wr = 0; host_rd = 0;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
        srd(); drd(); idle(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule